// File: doc/BRIEF.md
# Fast Interrupt Vectoring Unit

This unit turns a single dedicated fast interrupt source into an active-low fast interrupt request for a processor. It also hands the processor the address of the service routine for that source. Software programs the handler address, an enable bit, a trigger mode and an active polarity through a small register bus. The processor then takes the request. The handler's first step is to read the fast vector register, which returns the stored address.

In edge mode, the source is synchronised and an active edge sets a single pending flag. Reading the fast vector register acknowledges that flag and drops the request. The same read leaves a pending flag set if a new edge lands in that cycle. In level mode, the request simply follows the synchronised source. A vector read does not clear it, so the service routine must clear the source itself. There is no nesting: at most one pending event is remembered.

Top module: `fiq_vector_unit`

## Requirements
- R1: After reset, `fiq_req_no` is 1, and reads of the vector register (address 0) and the control register (address 1) return 0.
- R2: A write to address 0 stores `wdata_i` as the handler address. A read of address 0 returns it on `rdata_o` in the cycle after `rd_i` is sampled.
- R3: A read of address 2 (the fast vector register) returns the stored handler address with the same latency. Writes to address 2 are ignored.
- R4: The control register at address 1 has three fields, and reading it back returns the value written in those bits. Bit 0 is enable. Bit 1 selects the mode: 1 is edge, 0 is level. Bit 2 selects polarity: 0 means high level or rising edge, 1 means low level or falling edge.
- R5: In level mode with enable set, with two synchroniser stages, `fiq_req_no` goes low on the third rising edge after the source becomes active. It stays low across fast vector reads. It returns high on the third rising edge after the source goes inactive.
- R6: In edge mode with enable set, `fiq_req_no` goes low on the fourth rising edge after an active edge reaches the input. It stays low after the source returns inactive.
- R7: In edge mode, a fast vector read sampled on a clock edge clears the pending flag, and `fiq_req_no` is high one edge later.
- R8: A fast vector read while nothing is pending returns the address and changes nothing else.
- R9: If an active edge is detected in the same cycle as a clearing fast vector read, the pending flag stays set and the request stays asserted.
- R10: Clearing enable forces `fiq_req_no` high one edge after the control write is registered, and the edge-pending flag is kept. Setting enable again reasserts the request one edge after that write.
- R11: With polarity set to 1, a low level (level mode) or a falling edge (edge mode) is the active condition, and the opposite transition raises no request.
- R12: Only one pending event is held. Several edges before a read are cleared together by that single fast vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| src_i | input | 1 | Asynchronous fast interrupt source |
| fiq_req_no | output | 1 | Fast interrupt request, active low, registered |

## Verification
The bench builds the unit with DATA_W = 16 and SYNC_STAGES = 2. The narrower data path lets random handler addresses exercise every bit of the vector register. Two synchroniser stages fix the request latency at three edges in level mode and four in edge mode. That makes it possible to place a fast vector read on exactly the cycle in which an edge is detected. Random polarity and level patterns are mixed with directed edge, enable and collision sequences.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_VEC  = 2'd0,
    REG_CTRL = 2'd1,
    REG_FVR  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic act_low;
    logic edge_mode;
    logic enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/fiq_sync.sv
module fiq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/fiq_regs.sv
module fiq_regs
  import fiq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] vec_o,
  output ctrl_t             ctrl_o,
  output logic              fvr_rd_o
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o  <= '0;
      ctrl_o <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_VEC)  vec_o  <= wdata_i;
      if (addr_i == REG_CTRL) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_VEC, REG_FVR: rd_mux = vec_o;
      REG_CTRL:         rd_mux[CTRL_W-1:0] = ctrl_o;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign fvr_rd_o = rd_i && (addr_i == REG_FVR);
endmodule

// File: rtl/fiq_pend.sv
module fiq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic act_low_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic level_act_o,
  output logic edge_det_o,
  output logic pend_o
);
  logic prev_q;

  assign level_act_o = lvl_i ^ act_low_i;
  assign edge_det_o  = level_act_o & ~(prev_q ^ act_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a fresh edge outranks the acknowledge
      if (edge_mode_i) begin
        if (edge_det_o) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fiq_vector_unit.sv
module fiq_vector_unit
  import fiq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              src_i,
  output logic              fiq_req_no
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] vec;
  logic              fvr_rd, src_sync, level_act, edge_det, pend, req_cond;

  fiq_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .vec_o(vec), .ctrl_o(ctrl), .fvr_rd_o(fvr_rd)
  );

  fiq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(src_i), .q_o(src_sync)
  );

  fiq_pend i_pend (
    .clk_i, .rst_ni, .lvl_i(src_sync), .act_low_i(ctrl.act_low),
    .edge_mode_i(ctrl.edge_mode), .clr_i(fvr_rd),
    .level_act_o(level_act), .edge_det_o(edge_det), .pend_o(pend)
  );

  assign req_cond = ctrl.enable && (ctrl.edge_mode ? pend : level_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_req_no <= 1'b1;
    else         fiq_req_no <= ~req_cond;
  end
endmodule

// File: rtl/fiq_vector_unit_chk.sv
module fiq_vector_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              edge_mode_i,
  input logic              pend_i,
  input logic              level_act_i,
  input logic              edge_det_i,
  input logic              fvr_rd_i,
  input logic [DATA_W-1:0] vec_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              fiq_req_ni
);
  p_off_when_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> fiq_req_ni);

  p_fvr_returns_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fvr_rd_i |=> rdata_i == $past(vec_i));

  p_level_asserts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !edge_mode_i && level_act_i) |=> !fiq_req_ni);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fvr_rd_i && !edge_det_i) |=> !pend_i);

  p_edge_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && edge_det_i) |=> pend_i);

  p_pend_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && pend_i && !fvr_rd_i) |=> pend_i);
endmodule

bind fiq_vector_unit fiq_vector_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl.enable),
  .edge_mode_i(ctrl.edge_mode), .pend_i(pend), .level_act_i(level_act),
  .edge_det_i(edge_det), .fvr_rd_i(fvr_rd), .vec_i(vec),
  .rdata_i(rdata_o), .fiq_req_ni(fiq_req_no)
);

// File: tb/test_fiq_vector_unit.sv
module test_fiq_vector_unit;
  localparam int unsigned DATA_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_i = 1'b0, wr_i = 1'b0, src_i = 1'b0;
  logic [1:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              fiq_req_no;
  int checks = 0, errors = 0;
  logic [DATA_W-1:0] vec_model = '0;
  logic [DATA_W-1:0] got;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fiq_vector_unit #(.DATA_W(DATA_W), .SYNC_STAGES(2)) i_fiq_vector_unit (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i, .rdata_o, .src_i, .fiq_req_no
  );

  function automatic logic exp_req_n(input logic src, input logic act_low);
    return ~(src ^ act_low);
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 req", fiq_req_no, 1'b1);
    rd(2'd0, got); chk("R1 vec", got, '0);
    rd(2'd1, got); chk("R1 ctrl", got, '0);

    wr(2'd0, 16'hA5C3); vec_model = 16'hA5C3;
    rd(2'd0, got); chk("R2 vec", got, vec_model);
    rd(2'd2, got); chk("R3 fvr", got, vec_model);
    wr(2'd2, 16'h1111);
    rd(2'd0, got); chk("R3 fvr write ignored", got, vec_model);

    wr(2'd1, 16'h0003);
    rd(2'd1, got); chk("R4 ctrl", got, 16'h0003);

    // R6 edge latency and hold
    src_i = 1'b1; cyc(3); chk("R6 not yet", fiq_req_no, 1'b1);
    cyc(1); chk("R6 asserted", fiq_req_no, 1'b0);
    src_i = 1'b0; cyc(5); chk("R6 held", fiq_req_no, 1'b0);

    // R10 enable gating keeps pending
    wr(2'd1, 16'h0002); cyc(1); chk("R10 off", fiq_req_no, 1'b1);
    cyc(3); chk("R10 stays off", fiq_req_no, 1'b1);
    wr(2'd1, 16'h0003); cyc(1); chk("R10 reassert", fiq_req_no, 1'b0);

    // R12 second edge, single read clears all
    src_i = 1'b1; cyc(4); src_i = 1'b0; cyc(4);
    rd(2'd2, got); chk("R3 fvr edge", got, vec_model);
    cyc(1); chk("R7 cleared", fiq_req_no, 1'b1);
    cyc(5); chk("R12 single pending", fiq_req_no, 1'b1);

    // R8 idle read
    rd(2'd2, got); chk("R8 value", got, vec_model);
    cyc(3); chk("R8 no effect", fiq_req_no, 1'b1);

    // R9 edge collides with clearing read
    src_i = 1'b1; cyc(4); src_i = 1'b0; cyc(4);
    chk("R9 pending set", fiq_req_no, 1'b0);
    src_i = 1'b1; cyc(2);
    rd(2'd2, got);
    cyc(3); chk("R9 kept", fiq_req_no, 1'b0);
    rd(2'd2, got); cyc(1); chk("R9 later clear", fiq_req_no, 1'b1);
    src_i = 1'b0; cyc(4);

    // R5 level mode
    wr(2'd1, 16'h0001); cyc(1);
    chk("R5 idle", fiq_req_no, 1'b1);
    src_i = 1'b1; cyc(2); chk("R5 not yet", fiq_req_no, 1'b1);
    cyc(1); chk("R5 asserted", fiq_req_no, 1'b0);
    rd(2'd2, got); cyc(3); chk("R5 read no clear", fiq_req_no, 1'b0);
    src_i = 1'b0; cyc(3); chk("R5 released", fiq_req_no, 1'b1);

    // R11 active-low polarity
    wr(2'd1, 16'h0005); cyc(3); chk("R11 low level", fiq_req_no, 1'b0);
    src_i = 1'b1; cyc(3); chk("R11 high inactive", fiq_req_no, 1'b1);
    wr(2'd1, 16'h0007); cyc(3); chk("R11 no false edge", fiq_req_no, 1'b1);
    src_i = 1'b0; cyc(4); chk("R11 falling edge", fiq_req_no, 1'b0);
    rd(2'd2, got); cyc(1); chk("R11 cleared", fiq_req_no, 1'b1);
    src_i = 1'b1; cyc(5); chk("R11 rising ignored", fiq_req_no, 1'b1);

    // random vectors and level patterns
    for (int i = 0; i < 40; i++) begin
      logic pol;
      vec_model = DATA_W'($urandom);
      wr(2'd0, vec_model);
      rd(2'd2, got); chk("R3 random fvr", got, vec_model);
      pol = 1'($urandom);
      src_i = 1'($urandom);
      wr(2'd1, {13'd0, pol, 1'b0, 1'b1});
      cyc(4);
      chk("R5 random level", fiq_req_no, exp_req_n(src_i, pol));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule